// File: doc/BRIEF.md
# Event Timer Global Register Block

This block is the shared front end of a three-channel event timer. It answers 32-bit register reads and writes at fixed byte offsets: a read-only capability word, a read-only tick period word, a two-bit general configuration register, a status word and the main counter. The main counter is a 32-bit up-counter that advances by one on every clock while the global enable bit is set. It freezes when that bit is cleared and resumes from the frozen value when the bit is set again.

The per-channel comparators live in a separate block. That block takes the main counter and the global enable from this block. It returns one hit pulse per channel together with each channel's enable bit and its 5-bit line selector. When software reads the channel window, the comparator block also supplies the read data.

This block turns accepted hits into one-cycle pulses on a 32-line interrupt vector. A legacy routing bit overrides the selectors of channels 0 and 1.

Top module: `evt_timer_glb`

## Requirements
- R1: A read at offset 0x000 returns 0x80868201. The bits mean: 16-bit vendor field 0x8086, legacy-route capable at bit 15, 32-bit counter at bit 13 clear, channel count minus one at bits 12:8, and revision 1. A read at 0x004 returns the tick period 10,000,000 fs, which is 0x00989680.
- R2: The general configuration at offset 0x010 holds enable in bit 0 and legacy routing in bit 1. Only these two bits are stored, and all other bits read as zero. Writes to 0x000, 0x004, 0x014 and 0x020 change nothing. Reads at 0x014 and at the status offset 0x020 return zero.
- R3: While enable is 1, the main counter rises by one on each clock. While enable is 0, the counter holds its value, and a read at 0x0F0 returns that held value. When enable is set again, counting resumes from the held value.
- R4: A write at 0x0F0 loads the counter on the next edge, taking precedence over the increment, whether or not the counter is enabled. A write at 0x0F4 has no effect on the counter, and a read at 0x0F4 returns zero.
- R5: Read data appears on the clock edge that samples the read strobe. It then holds until the next read.
- R6: With legacy routing clear, an accepted hit of channel i pulses the interrupt line whose number is channel i's 5-bit selector. Channel i's selector sits at bits 5i+4:5i of the route input.
- R7: With legacy routing set, a channel 0 hit pulses lines 0 and 2, and a channel 1 hit pulses line 8, whatever their selectors say. Channel 2 keeps its selector.
- R8: A hit is accepted only when both that channel's enable and the global enable are 1.
- R9: An interrupt pulse lasts one cycle, one edge after the hit. Hits from several channels in the same cycle are OR-combined on the vector.
- R10: Offsets from 0x100 upward form channel windows with a stride of 0x20. Reads in windows 0 to 2 return the channel read data input. Windows 3 and above, and any other unmapped offset, read zero.
- R11: A synchronous reset clears the configuration, the counter, the read data and the interrupt vector to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ch_rdata | input | 32 | Read data from the channel block for the addressed window |
| ch_en | input | 3 | Per-channel enable bits |
| ch_hit | input | 3 | Per-channel comparator hit pulses |
| ch_route | input | 15 | Three packed 5-bit line selectors |
| main_count | output | 32 | Main counter value |
| glb_en | output | 1 | Global enable bit |
| irq_pulse | output | 32 | One-cycle interrupt line pulses |

## Verification
Every result arrives exactly one clock edge after its cause. Read data follows the edge that samples the strobe. The counter follows the edge that samples a write or a set enable. An interrupt pulse follows the edge that samples the hit, and it clears one edge later. The bench drives stimulus at falling edges and keeps a behavioural model that advances at each rising edge. It compares every output at the next falling edge, so each result is sampled half a cycle after the edge that produced it. The targeted checks use the same timing, and the counter values they expect are worked out from the number of rising edges that pass while enable is set.

// File: rtl/evt_timer_glb.sv
`timescale 1ns/1ps
module evt_timer_glb #(
  parameter int NCH       = 3,
  parameter int ROUTE_W   = 5,
  parameter int IRQ_W     = 32,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int STRIDE_LG = 5,
  parameter int PERIOD_FS = 10_000_000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic [DATA_W-1:0]        ch_rdata,
  input  logic [NCH-1:0]           ch_en,
  input  logic [NCH-1:0]           ch_hit,
  input  logic [NCH*ROUTE_W-1:0]   ch_route,
  output logic [DATA_W-1:0]        main_count,
  output logic                     glb_en,
  output logic [IRQ_W-1:0]         irq_pulse
);

  localparam logic [ADDR_W-1:0] A_CAP    = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(12'h0F0);
  localparam logic [ADDR_W-1:0] A_CH     = ADDR_W'(12'h100);
  localparam logic [DATA_W-1:0] CAP_WORD =
    DATA_W'({16'h8086, 1'b1, 1'b0, 1'b0, 5'(NCH-1), 8'h01});
  localparam logic [DATA_W-1:0] PERIOD_WORD = DATA_W'(PERIOD_FS);
  localparam int LEG0_A = 0;
  localparam int LEG0_B = 2;
  localparam int LEG1   = 8;

  logic [1:0]        cfg_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] rd_mux;
  logic [ADDR_W-1:0] ch_idx;
  logic [IRQ_W-1:0]  irq_d;
  logic [IRQ_W-1:0]  ch_vec [NCH];
  logic              wr_cfg, wr_cnt;

  assign wr_cfg     = reg_wr && (reg_addr == A_CFG);
  assign wr_cnt     = reg_wr && (reg_addr == A_CNT_LO);
  assign ch_idx     = ADDR_W'(reg_addr - A_CH) >> STRIDE_LG;
  assign main_count = cnt_q;
  assign glb_en     = cfg_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= reg_wdata;
    end else if (cfg_q[0]) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr >= A_CH) begin
      if (ch_idx < ADDR_W'(NCH)) rd_mux = ch_rdata;
    end else if (reg_addr == A_CAP) begin
      rd_mux = CAP_WORD;
    end else if (reg_addr == A_PERIOD) begin
      rd_mux = PERIOD_WORD;
    end else if (reg_addr == A_CFG) begin
      rd_mux = DATA_W'(cfg_q);
    end else if (reg_addr == A_CNT_LO) begin
      rd_mux = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic fire;
    assign fire = ch_hit[i] && ch_en[i] && cfg_q[0];
    assign ch_vec[i] =
      !fire                  ? '0 :
      (cfg_q[1] && i == 0)   ? ((IRQ_W'(1) << LEG0_A) | (IRQ_W'(1) << LEG0_B)) :
      (cfg_q[1] && i == 1)   ? (IRQ_W'(1) << LEG1) :
                               (IRQ_W'(1) << ch_route[i*ROUTE_W +: ROUTE_W]);
  end

  always_comb begin
    irq_d = '0;
    for (int i = 0; i < NCH; i++) irq_d = irq_d | ch_vec[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse <= '0;
    end else begin
      irq_pulse <= irq_d;
    end
  end

endmodule

// File: rtl/evt_timer_glb_chk.sv
`timescale 1ns/1ps
module evt_timer_glb_chk #(
  parameter int IRQ_W  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int NCH    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NCH-1:0]    ch_hit,
  input logic [DATA_W-1:0] main_count,
  input logic              glb_en,
  input logic [IRQ_W-1:0]  irq_pulse
);
  localparam logic [ADDR_W-1:0] CNT_LO = ADDR_W'(12'h0F0);
  localparam logic [ADDR_W-1:0] CAP_A  = ADDR_W'(12'h000);

  p_cap_read_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == CAP_A) |=> reg_rdata == 32'h80868201);

  p_count_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !(reg_wr && reg_addr == CNT_LO)) |=> $stable(main_count));

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (glb_en && !(reg_wr && reg_addr == CNT_LO)) |=> main_count == $past(main_count) + 1'b1);

  p_count_load_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == CNT_LO) |=> main_count == $past(reg_wdata));

  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> irq_pulse == '0);

  p_no_hit_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (ch_hit == '0) |=> irq_pulse == '0);
endmodule

bind evt_timer_glb evt_timer_glb_chk #(
  .IRQ_W(IRQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)
) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_hit(ch_hit),
  .main_count(main_count), .glb_en(glb_en), .irq_pulse(irq_pulse)
);

// File: tb/evt_timer_glb_tb_top.sv
`timescale 1ns/1ps
module evt_timer_glb_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] ch_rdata = 32'hA5A5_0000;
  logic [2:0]  ch_en = '0, ch_hit = '0;
  logic [14:0] ch_route = {5'd5, 5'd9, 5'd5};
  logic [31:0] main_count;
  logic        glb_en;
  logic [31:0] irq_pulse;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;

  logic [31:0] m_cfg = '0, m_cnt = '0, m_rdata = '0, m_irq = '0;

  always #2.5 clk = ~clk;

  evt_timer_glb dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_rdata(ch_rdata),
    .ch_en(ch_en), .ch_hit(ch_hit), .ch_route(ch_route),
    .main_count(main_count), .glb_en(glb_en), .irq_pulse(irq_pulse)
  );

  function automatic logic [31:0] model_read(input int a);
    if (a >= 256) return (((a - 256) / 32) < 3) ? ch_rdata : 32'h0;
    if (a == 0)   return 32'h80868201;
    if (a == 4)   return 32'd10_000_000;
    if (a == 16)  return m_cfg;
    if (a == 240) return m_cnt;
    return 32'h0;
  endfunction

  function automatic logic [31:0] model_irq();
    logic [31:0] v = '0;
    for (int i = 0; i < 3; i++) begin
      if (ch_hit[i] && ch_en[i] && m_cfg[0]) begin
        if (m_cfg[1] && i == 0)      v = v | 32'h5;
        else if (m_cfg[1] && i == 1) v = v | 32'h100;
        else                         v = v | (32'h1 << ch_route[i*5 +: 5]);
      end
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg <= '0; m_cnt <= '0; m_rdata <= '0; m_irq <= '0;
    end else begin
      if (reg_rd) m_rdata <= model_read(int'(reg_addr));
      if (reg_wr && reg_addr == 10'h010) m_cfg <= reg_wdata & 32'h3;
      if (reg_wr && reg_addr == 10'h0F0) m_cnt <= reg_wdata;
      else if (m_cfg[0]) m_cnt <= m_cnt + 1;
      m_irq <= model_irq();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 model main_count", main_count, m_cnt);
      chk("R2 model glb_en", {31'b0, glb_en}, {31'b0, m_cfg[0]});
      chk("R5 model reg_rdata", reg_rdata, m_rdata);
      chk("R6 model irq_pulse", irq_pulse, m_irq);
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic hit(input logic [2:0] m, input logic [31:0] exp, input string tag);
    ch_hit = m;
    @(negedge clk);
    ch_hit = '0;
    chk(tag, irq_pulse, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;
    chk("R11 reset count", main_count, 32'h0);
    chk("R11 reset rdata", reg_rdata, 32'h0);
    chk("R11 reset irq", irq_pulse, 32'h0);
    chk("R11 reset enable", {31'b0, glb_en}, 32'h0);

    rd(10'h000, 32'h80868201, "R1 capability");
    rd(10'h004, 32'h00989680, "R1 period");

    wr(10'h010, 32'hFFFF_FFFC);
    rd(10'h010, 32'h0, "R2 upper config bits dropped");
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, 32'h0, "R2 high config word");
    wr(10'h000, 32'h0);
    rd(10'h000, 32'h80868201, "R2 capability write ignored");
    wr(10'h020, 32'hFFFF_FFFF);
    rd(10'h020, 32'h0, "R2 status reads zero");
    wr(10'h010, 32'h2);
    rd(10'h010, 32'h2, "R2 legacy bit stored");
    wr(10'h010, 32'h0);

    wr(10'h0F0, 32'h1234);
    rd(10'h0F0, 32'h1234, "R4 counter load while halted");
    wr(10'h0F4, 32'hFFFF);
    rd(10'h0F0, 32'h1234, "R4 upper write no effect");
    rd(10'h0F4, 32'h0, "R4 upper read zero");

    repeat (5) @(negedge clk);
    rd(10'h0F0, 32'h1234, "R3 halted counter holds");
    wr(10'h010, 32'h1);
    repeat (10) @(negedge clk);
    wr(10'h010, 32'h0);
    rd(10'h0F0, 32'h123F, "R3 counted eleven edges then froze");
    repeat (5) @(negedge clk);
    rd(10'h0F0, 32'h123F, "R3 frozen value holds");
    repeat (3) @(negedge clk);
    chk("R5 read data held", reg_rdata, 32'h123F);
    wr(10'h010, 32'h1);
    repeat (3) @(negedge clk);
    wr(10'h0F0, 32'h0);
    chk("R4 load while enabled", main_count, 32'h0);

    rd(10'h100, 32'hA5A5_0000, "R10 window 0");
    rd(10'h140, 32'hA5A5_0000, "R10 window 2");
    rd(10'h160, 32'h0, "R10 window 3 zero");
    rd(10'h3E0, 32'h0, "R10 last window zero");
    rd(10'h0F8, 32'h0, "R10 unmapped zero");

    ch_en = 3'b111;
    hit(3'b001, 32'h20, "R6 channel 0 selector");
    hit(3'b110, 32'h220, "R9 two channels OR");
    hit(3'b111, 32'h220, "R9 shared line OR");
    @(negedge clk);
    chk("R9 pulse lasts one cycle", irq_pulse, 32'h0);

    ch_en = 3'b110;
    hit(3'b001, 32'h0, "R8 channel disabled");
    ch_en = 3'b111;
    wr(10'h010, 32'h0);
    hit(3'b111, 32'h0, "R8 global disabled");

    wr(10'h010, 32'h3);
    hit(3'b001, 32'h5, "R7 legacy channel 0");
    hit(3'b010, 32'h100, "R7 legacy channel 1");
    hit(3'b100, 32'h20, "R7 channel 2 keeps selector");
    hit(3'b111, 32'h125, "R7 legacy all");
    repeat (4) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule